// File: doc/BRIEF.md
# Dataless Valid-Ready FIFO Controller

This block is the flow-control half of a FIFO for a channel whose payload is zero bits wide. It has no data ports. It only counts tokens. Each accepted push adds one token, each accepted pop removes one, and the count is kept between zero and `DEPTH`. The push-side `push_ready` and the pop-side `pop_valid` are the only signals it reports. Producers and consumers that only need to trade "an event happened" tokens can connect to it directly, with no storage to build.

Three build-time options shape the handshake:
- `BYPASS` lets a token offered to an empty controller come out on the pop side in the same cycle.
- `REG_PUSH` makes `push_ready` come from a flop instead of combinational logic.
- `REG_POP` does the same for `pop_valid`.

Reset is synchronous and active-high.

Top module: `tok_fifo_ctl`

## Requirements
- R1: In the first cycle after `rst` is released, with `push_valid` low, `push_ready` is 1 and `pop_valid` is 0, because the token count has been cleared to zero.
- R2: At each rising clock edge the count goes up by one when push completes alone (`push_valid` and `push_ready` both 1). It goes down by one when pop completes alone (`pop_valid` and `pop_ready` both 1). It stays the same when both complete or neither does.
- R3: The count never goes above `DEPTH` or below zero. `push_ready` is low only when the count equals `DEPTH`.
- R4: With `REG_POP`=0, `pop_valid` is 1 when the count is above zero. It is also 1 when the count is zero, `BYPASS`=1 and `push_valid` is 1. It is 0 otherwise.
- R5: A bypass transfer is a push and a pop that both complete while the count is zero. It leaves the count at zero, so `pop_valid` is low in the next cycle if no new push is offered.
- R6: With `REG_PUSH`=1, `push_ready` comes from a flop and equals (count < `DEPTH`) for the count at the start of the cycle. A full controller does not accept a push in the same cycle as a pop. It accepts one in the following cycle.
- R7: With `REG_PUSH`=0, `push_ready` is 1 when the count is below `DEPTH`. It is also 1 when the count equals `DEPTH` and `pop_ready` is 1, so a full controller can take a push in the same cycle as a pop.
- R8: With `REG_POP`=1, `pop_valid` comes from a flop and equals (count > 0). `BYPASS` then has no effect, and an empty controller never shows `pop_valid` in the same cycle as a push.
- R9: `DEPTH`=1 is supported and follows R1 to R8, with a count that holds only the values 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the token count |
| push_valid | input | 1 | Producer offers a token |
| push_ready | output | 1 | Controller can accept a token this cycle |
| pop_valid | output | 1 | A token is available to the consumer this cycle |
| pop_ready | input | 1 | Consumer takes the offered token |

## Verification
The hardest state to reach from the ports is a full controller that sees a push and a pop in the same cycle. This is where the registered and combinational `push_ready` variants differ. The stimulus reaches it on purpose: it offers pushes with `pop_ready` held low until the count reaches `DEPTH`, then raises both sides for several cycles. Bypass from empty is driven the same way, with one-cycle push-and-pop bursts separated by idle cycles, so the cycle after each bypass shows that no token was left behind. All sixteen option and depth combinations then run long random phases whose push and pop densities are skewed in both directions. These phases hold the count near each limit for many cycles.

// File: rtl/tok_fifo_pkg.sv
package tok_fifo_pkg;

  // Width of a counter that must hold every value 0..depth inclusive.
  function automatic int occ_width(input int depth);
    return (depth < 1) ? 1 : $clog2(depth + 1);
  endfunction

  // Next token count from the current count and this cycle's completions.
  function automatic int occ_step(input int cur, input logic up, input logic down);
    return cur + (up ? 1 : 0) - (down ? 1 : 0);
  endfunction

endpackage

// File: rtl/tok_fifo_occ.sv
module tok_fifo_occ #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_nxt
);

  always_comb occ_nxt = CW'(tok_fifo_pkg::occ_step(int'(occ), inc, dec));

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ_nxt;
  end

endmodule

// File: rtl/tok_fifo_flag.sv
module tok_fifo_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/tok_fifo_ctl.sv
module tok_fifo_ctl #(
  parameter int unsigned DEPTH    = 4,
  parameter bit          BYPASS   = 1'b0,
  parameter bit          REG_PUSH = 1'b0,
  parameter bit          REG_POP  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic push_valid,
  output logic push_ready,
  output logic pop_valid,
  input  logic pop_ready
);

  localparam int            CW      = tok_fifo_pkg::occ_width(int'(DEPTH));
  localparam bit            PASS_ON = BYPASS && !REG_POP;
  localparam logic [CW-1:0] OCC_MAX = CW'(DEPTH);

  // Named internal events, visible to the bound checker.
  logic [CW-1:0] occ;
  logic [CW-1:0] occ_nxt;
  logic          occ_empty;
  logic          push_fire;
  logic          pop_fire;
  logic          bypass_xfer;

  assign occ_empty   = (occ == '0);
  assign push_fire   = push_valid & push_ready;
  assign pop_fire    = pop_valid & pop_ready;
  assign bypass_xfer = PASS_ON & occ_empty & push_fire & pop_fire;

  tok_fifo_occ #(.CW(CW)) u_occ (
    .clk     (clk),
    .rst     (rst),
    .inc     (push_fire),
    .dec     (pop_fire),
    .occ     (occ),
    .occ_nxt (occ_nxt)
  );

  // Push-side acceptance: flopped from the next count, or live with pop look-through.
  if (REG_PUSH) begin : g_push_reg
    tok_fifo_flag #(.RST_VAL(1'b1)) u_push_flag (
      .clk (clk),
      .rst (rst),
      .d   (occ_nxt != OCC_MAX),
      .q   (push_ready)
    );
  end else begin : g_push_comb
    assign push_ready = (occ != OCC_MAX) || pop_ready;
  end

  // Pop-side availability: flopped from the next count, or live with optional bypass.
  if (REG_POP) begin : g_pop_reg
    tok_fifo_flag #(.RST_VAL(1'b0)) u_pop_flag (
      .clk (clk),
      .rst (rst),
      .d   (occ_nxt != '0),
      .q   (pop_valid)
    );
  end else begin : g_pop_comb
    assign pop_valid = !occ_empty || (PASS_ON && push_valid);
  end

endmodule

// File: rtl/tok_fifo_ctl_chk.sv
module tok_fifo_ctl_chk #(
  parameter int unsigned DEPTH    = 4,
  parameter int          CW       = 3,
  parameter bit          REG_PUSH = 1'b0,
  parameter bit          REG_POP  = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic          push_ready,
  input logic          pop_valid,
  input logic [CW-1:0] occ,
  input logic          push_fire,
  input logic          pop_fire,
  input logic          bypass_xfer
);

  localparam logic [CW-1:0] OCC_MAX = CW'(DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= int'(DEPTH));

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_fire && !push_fire) |-> (occ != '0));

  assert_stall_only_full_R3: assert property (@(posedge clk) disable iff (rst)
    !push_ready |-> (occ == OCC_MAX));

  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    (push_fire && !pop_fire) |=> (occ == $past(occ) + CW'(1)));

  assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
    (pop_fire && !push_fire) |=> (occ == $past(occ) - CW'(1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (push_fire == pop_fire) |=> $stable(occ));

  assert_bypass_leaves_empty_R5: assert property (@(posedge clk) disable iff (rst)
    bypass_xfer |=> (occ == '0));

  assert_idle_only_empty_R4: assert property (@(posedge clk) disable iff (rst)
    !pop_valid |-> (occ == '0));

  if (REG_PUSH) begin : g_push_chk
    assert_ready_means_room_R6: assert property (@(posedge clk) disable iff (rst)
      push_ready |-> (occ != OCC_MAX));
  end

  if (REG_POP) begin : g_pop_chk
    assert_valid_means_token_R8: assert property (@(posedge clk) disable iff (rst)
      pop_valid |-> (occ != '0));
  end

endmodule

bind tok_fifo_ctl tok_fifo_ctl_chk #(
  .DEPTH    (DEPTH),
  .CW       (CW),
  .REG_PUSH (REG_PUSH),
  .REG_POP  (REG_POP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .push_ready  (push_ready),
  .pop_valid   (pop_valid),
  .occ         (occ),
  .push_fire   (push_fire),
  .pop_fire    (pop_fire),
  .bypass_xfer (bypass_xfer)
);

// File: tb/sim_tok_fifo_ctl.sv
module sim_lane #(
  parameter int DEPTH    = 4,
  parameter bit BYPASS   = 1'b0,
  parameter bit REG_PUSH = 1'b0,
  parameter bit REG_POP  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  output int   checks,
  output int   fails,
  output logic done
);

  logic push_valid;
  logic pop_ready;
  logic push_ready;
  logic pop_valid;

  tok_fifo_ctl #(
    .DEPTH    (DEPTH),
    .BYPASS   (BYPASS),
    .REG_PUSH (REG_PUSH),
    .REG_POP  (REG_POP)
  ) u0 (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready)
  );

  // Reference model: a plain token tally.
  int level;
  bit last_bypass;
  int push_dens [6] = '{50, 90, 20, 70, 100, 30};
  int pop_dens  [6] = '{50, 20, 90, 70, 30, 100};

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s (DEPTH=%0d BYPASS=%0d REG_PUSH=%0d REG_POP=%0d level=%0d) actual=%0b expected=%0b",
               tag, what, DEPTH, BYPASS, REG_PUSH, REG_POP, level, act, exp);
    end
  endtask

  task automatic step(input bit pv, input bit pr);
    logic  exp_ready;
    logic  exp_valid;
    bit    pf;
    bit    qf;
    string t_push;
    string t_pop;
    @(negedge clk);
    push_valid = pv;
    pop_ready  = pr;
    #1;
    exp_ready = REG_PUSH ? (level < DEPTH) : ((level < DEPTH) || pr);
    exp_valid = REG_POP  ? (level > 0)     : ((level > 0) || (BYPASS && pv));
    t_push = REG_PUSH ? "R6" : "R7";
    if (level == DEPTH) t_push = {t_push, " R3"};
    if (DEPTH == 1)     t_push = {t_push, " R9"};
    t_pop = REG_POP ? "R8 R2" : "R4 R2";
    if (last_bypass)    t_pop = {t_pop, " R5"};
    if (DEPTH == 1)     t_pop = {t_pop, " R9"};
    check(t_push, "push_ready", push_ready, exp_ready);
    check(t_pop,  "pop_valid",  pop_valid,  exp_valid);
    pf = pv && exp_ready;
    qf = exp_valid && pr;
    last_bypass = pf && qf && (level == 0);
    level = level + (pf ? 1 : 0) - (qf ? 1 : 0);
  endtask

  initial begin
    push_valid  = 1'b0;
    pop_ready   = 1'b0;
    level       = 0;
    last_bypass = 1'b0;
    checks      = 0;
    fails       = 0;
    done        = 1'b0;
    wait (rst == 1'b0);
    @(negedge clk);
    #1;
    check("R1", "push_ready after reset", push_ready, 1'b1);
    check("R1", "pop_valid after reset",  pop_valid,  1'b0);
    // Fill to the limit, then push and pop together while full, then drain.
    for (int pass = 0; pass < 2; pass++) begin
      repeat (DEPTH + 2) step(1'b1, 1'b0);
      repeat (4)         step(1'b1, 1'b1);
      repeat (DEPTH + 2) step(1'b0, 1'b1);
      // Bypass bursts from empty, each followed by an idle cycle.
      repeat (6) begin
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
      end
    end
    // Random phases with skewed densities.
    for (int ph = 0; ph < 6; ph++) begin
      repeat (300) step(int'($urandom_range(99)) < push_dens[ph],
                        int'($urandom_range(99)) < pop_dens[ph]);
    end
    done = 1'b1;
  end

endmodule

module sim_tok_fifo_ctl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int         lane_checks [16];
  int         lane_fails  [16];
  logic [15:0] lane_done;
  int         total_checks;
  int         total_fails;
  bit         finished = 1'b0;

  for (genvar g = 0; g < 16; g++) begin : g_lane
    sim_lane #(
      .DEPTH    ((g >= 8) ? 4 : 1),
      .BYPASS   ((g % 2) == 1),
      .REG_PUSH (((g / 2) % 2) == 1),
      .REG_POP  (((g / 4) % 2) == 1)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .checks (lane_checks[g]),
      .fails  (lane_fails[g]),
      .done   (lane_done[g])
    );
  end

  task automatic sum_up();
    total_checks = 0;
    total_fails  = 0;
    for (int i = 0; i < 16; i++) begin
      total_checks += lane_checks[i];
      total_fails  += lane_fails[i];
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait (&lane_done);
    #1;
    sum_up();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", total_checks, total_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      sum_up();
      total_checks++;
      total_fails++;
      $display("FAIL watchdog: lanes done=%b actual=timeout expected=completion", lane_done);
      $display("End of test - %0d assertions evaluated, %0d failures", total_checks, total_fails);
      $finish;
    end
  end

endmodule